// File: doc/BRIEF.md
# Fenced DMA Descriptor Sequencer

This block runs memory-transfer descriptors for a single channel, one after another and in the order they arrive. Each descriptor names an operation, a source word address, a destination word address, a length in bytes, a 64-bit fill value, a fence flag and an interrupt-request flag. The supported operations are a copy, a fill with one repeated 64-bit value, and an empty operation that moves no data. The block talks to one word-addressed memory port that carries 64-bit words. When a descriptor is finished, the block raises a one-cycle completion pulse that returns the interrupt flag and an error flag.

A reader stage takes in descriptors and checks them. It fetches source words, or generates fill words, into a data queue. A writer stage drains that queue to the destination. Because the two stages are split, the reader may start fetching the next descriptor's source while the writer is still storing the previous descriptor's data. Software blocks this overlap on a dependent descriptor by setting its fence flag. The block then holds back every read of that descriptor until all earlier writes have been granted by memory.

Any descriptor the block rejects produces an error completion. After that the block accepts nothing more until the clear input is pulsed.

Top module: `dma_fence_seq`

## Requirements
- R1: Completions appear in the order the descriptors were accepted, exactly one completion for each descriptor.
- R2: A copy of N bytes writes destination words 0..N/8-1 with the values of the matching source words.
- R3: A fill of N bytes writes the 64-bit fill value to each of the N/8 destination words.
- R4: An empty operation (code 0) makes no memory request, whatever its length field holds, and still completes.
- R5: For a descriptor with the fence flag set, its first source read is granted only after the last write of every earlier descriptor has been granted.
- R6: Without the fence flag, source reads of the following copy are granted while the previous copy still has writes outstanding.
- R7: A copy or fill longer than MAX_BYTES (default 1 MiB) completes with the error flag set and makes no memory request. A length of exactly MAX_BYTES is carried out normally.
- R8: A copy or fill whose length is not a multiple of 8 completes with the error flag set and makes no memory request.
- R9: A copy or fill of length zero completes without error and makes no memory request.
- R10: The completion carries the interrupt flag of its own descriptor.
- R11: After a descriptor is rejected, desc_ready stays low and no descriptor is accepted until halt_clear is high for one cycle. After that, descriptors are accepted again.
- R12: Operation codes are 0 = empty, 1 = copy, 2 = fill. Code 3 is rejected with an error completion and no memory request.
- R13: Out of reset, desc_ready is high and mem_req and cpl_valid are low. A raised request keeps its address, direction and write data until mem_gnt is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_clear | input | 1 | Leaves the halted state after an error |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken at this edge when valid |
| desc_op | input | 2 | Operation code (0 empty, 1 copy, 2 fill, 3 invalid) |
| desc_fence | input | 1 | Wait for earlier writes before reading |
| desc_irq | input | 1 | Interrupt flag returned on completion |
| desc_src | input | AW | Source word address |
| desc_dst | input | AW | Destination word address |
| desc_len | input | LW | Length in bytes |
| desc_pattern | input | DW | Fill value |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted at this edge |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_irq | output | 1 | Interrupt flag of the completed descriptor |
| cpl_err | output | 1 | Descriptor was rejected |

## Verification
The assertions rely on the memory returning exactly one read response for each granted read, in grant order, some cycles after the grant. They also rely on it returning nothing for writes. The bench memory keeps to this with a fixed two-cycle read pipe, and it throttles grants only through mem_gnt. Descriptors are held steady while offered. Dependent copies without a fence are never placed where stale data would change the reference image, so the expected memory contents stay well defined.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [1:0] {
    OP_NULL = 2'd0,
    OP_COPY = 2'd1,
    OP_FILL = 2'd2,
    OP_RSVD = 2'd3
  } dseq_op_e;
endpackage

// File: rtl/dseq_fifo.sv
module dseq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  ram [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) ram[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= bump(wptr_q);
      if (pop)  rptr_q <= bump(rptr_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign dout  = ram[rptr_q];
  assign count = cnt_q;

  // R2
  fifo_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q != CW'(DEPTH)) || pop);
  // R2
  fifo_udf_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/dseq_reader.sv
module dseq_reader
  import dseq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 64,
  parameter int LW        = 32,
  parameter int MAX_BYTES = 1 << 20,
  parameter int DDEPTH    = 8,
  parameter int JDEPTH    = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              halt_clear,
  input  logic                              desc_valid,
  output logic                              desc_ready,
  input  logic [1:0]                        desc_op,
  input  logic                              desc_fence,
  input  logic                              desc_irq,
  input  logic [AW-1:0]                     desc_src,
  input  logic [AW-1:0]                     desc_dst,
  input  logic [LW-1:0]                     desc_len,
  input  logic [DW-1:0]                     desc_pattern,
  input  logic                              job_full,
  output logic                              job_push,
  output logic [AW+$clog2(MAX_BYTES/8+1)+1:0] job_data,
  input  logic                              job_done,
  input  logic                              wr_in_port,
  output logic                              rd_want,
  output logic [AW-1:0]                     rd_addr,
  input  logic                              rd_go,
  input  logic                              mem_rvalid,
  input  logic [DW-1:0]                     mem_rdata,
  input  logic [$clog2(DDEPTH+1)-1:0]       dat_count,
  output logic                              dat_push,
  output logic [DW-1:0]                     dat_din,
  output logic                              fwait
);
  localparam int WCW = $clog2(MAX_BYTES / 8 + 1);
  localparam int DCW = $clog2(DDEPTH + 1);
  localparam int PCW = $clog2(JDEPTH + 2);

  typedef enum logic [2:0] {R_IDLE, R_FWAIT, R_READ, R_FILL, R_HALT} rd_st_e;

  rd_st_e         st_q;
  dseq_op_e       op_q;
  logic [AW-1:0]  addr_q, dst_q;
  logic [WCW-1:0] cnt_q;
  logic           irq_q;
  logic [DW-1:0]  pat_q;
  logic [DCW-1:0] inflight_q;
  logic [PCW-1:0] pend_q;

  dseq_op_e       op_in;
  logic           oversize, misalign, bad, no_data, take, fence_ok, space, fill_push;
  logic [WCW-1:0] words_in, job_words;

  assign op_in     = dseq_op_e'(desc_op);
  assign oversize  = desc_len > LW'(MAX_BYTES);
  assign misalign  = |desc_len[2:0];
  assign bad       = (op_in == OP_RSVD) || ((op_in != OP_NULL) && (oversize || misalign));
  assign no_data   = (op_in == OP_NULL) || (desc_len == '0);
  assign words_in  = WCW'(desc_len >> 3);
  assign job_words = (bad || no_data) ? '0 : words_in;

  assign desc_ready = (st_q == R_IDLE) && !job_full;
  assign take       = desc_valid && desc_ready;
  // earlier jobs all written and the last write has left the port
  assign fence_ok   = (pend_q == '0) && !wr_in_port;
  assign space      = ({1'b0, dat_count} + {1'b0, inflight_q}) < (DCW + 1)'(DDEPTH);
  assign rd_want    = (st_q == R_READ) && space;
  assign rd_addr    = addr_q;
  assign fill_push  = (st_q == R_FILL) && (inflight_q == '0) && space;
  assign dat_push   = mem_rvalid || fill_push;
  assign dat_din    = mem_rvalid ? mem_rdata : pat_q;
  assign job_push   = (take && (bad || no_data || !desc_fence)) ||
                      ((st_q == R_FWAIT) && fence_ok);
  assign job_data   = take ? {desc_dst, job_words, desc_irq, bad}
                           : {dst_q, cnt_q, irq_q, 1'b0};
  assign fwait      = (st_q == R_FWAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= R_IDLE;
      inflight_q <= '0;
      pend_q     <= '0;
      op_q       <= OP_NULL;
      addr_q     <= '0;
      dst_q      <= '0;
      cnt_q      <= '0;
      irq_q      <= 1'b0;
      pat_q      <= '0;
    end else begin
      inflight_q <= inflight_q + DCW'(rd_go) - DCW'(mem_rvalid);
      pend_q     <= pend_q + PCW'(job_push) - PCW'(job_done);
      unique case (st_q)
        R_IDLE: if (take) begin
          op_q   <= op_in;
          addr_q <= desc_src;
          dst_q  <= desc_dst;
          cnt_q  <= words_in;
          irq_q  <= desc_irq;
          pat_q  <= desc_pattern;
          if (bad)             st_q <= R_HALT;
          else if (no_data)    st_q <= R_IDLE;
          else if (desc_fence) st_q <= R_FWAIT;
          else                 st_q <= (op_in == OP_COPY) ? R_READ : R_FILL;
        end
        R_FWAIT: if (fence_ok) st_q <= (op_q == OP_COPY) ? R_READ : R_FILL;
        R_READ: if (rd_go) begin
          addr_q <= addr_q + AW'(1);
          cnt_q  <= cnt_q - WCW'(1);
          if (cnt_q == WCW'(1)) st_q <= R_IDLE;
        end
        R_FILL: if (fill_push) begin
          cnt_q <= cnt_q - WCW'(1);
          if (cnt_q == WCW'(1)) st_q <= R_IDLE;
        end
        R_HALT: if (halt_clear) st_q <= R_IDLE;
        default: st_q <= R_IDLE;
      endcase
    end
  end

  // R7
  oversize_chk: assert property (@(posedge clk) disable iff (rst)
    (take && (op_in != OP_NULL) && oversize) |=> (st_q == R_HALT) && !rd_want);
  // R11
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (take && (op_in == OP_RSVD)) |=> !desc_ready);
  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == R_HALT) && !halt_clear) |=> !desc_ready);
endmodule

// File: rtl/dseq_writer.sv
module dseq_writer #(
  parameter int AW        = 16,
  parameter int DW        = 64,
  parameter int MAX_BYTES = 1 << 20
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                job_empty,
  input  logic [AW+$clog2(MAX_BYTES/8+1)+1:0] job_data,
  output logic                                job_pop,
  input  logic                                dat_empty,
  input  logic [DW-1:0]                       dat_dout,
  output logic                                dat_pop,
  output logic                                wr_want,
  output logic [AW-1:0]                       wr_addr,
  output logic [DW-1:0]                       wr_data,
  input  logic                                wr_go,
  output logic                                job_done,
  output logic                                cpl_valid,
  output logic                                cpl_irq,
  output logic                                cpl_err
);
  localparam int WCW = $clog2(MAX_BYTES / 8 + 1);
  localparam int JW  = AW + WCW + 2;

  typedef enum logic {W_IDLE, W_WRITE} wr_st_e;

  wr_st_e         st_q;
  logic [AW-1:0]  addr_q;
  logic [WCW-1:0] cnt_q;
  logic           irq_q;

  logic [AW-1:0]  j_dst;
  logic [WCW-1:0] j_words;
  logic           j_irq, j_err;

  assign j_dst   = job_data[JW-1 -: AW];
  assign j_words = job_data[WCW+1:2];
  assign j_irq   = job_data[1];
  assign j_err   = job_data[0];

  assign job_pop  = (st_q == W_IDLE) && !job_empty;
  assign wr_want  = (st_q == W_WRITE) && !dat_empty;
  assign wr_addr  = addr_q;
  assign wr_data  = dat_dout;
  assign dat_pop  = wr_go;
  assign job_done = (job_pop && (j_words == '0)) || (wr_go && (cnt_q == WCW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= W_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      irq_q     <= 1'b0;
      cpl_valid <= 1'b0;
      cpl_irq   <= 1'b0;
      cpl_err   <= 1'b0;
    end else begin
      cpl_valid <= 1'b0;
      unique case (st_q)
        W_IDLE: if (job_pop) begin
          if (j_words == '0) begin
            cpl_valid <= 1'b1;
            cpl_irq   <= j_irq;
            cpl_err   <= j_err;
          end else begin
            addr_q <= j_dst;
            cnt_q  <= j_words;
            irq_q  <= j_irq;
            st_q   <= W_WRITE;
          end
        end
        W_WRITE: if (wr_go) begin
          addr_q <= addr_q + AW'(1);
          cnt_q  <= cnt_q - WCW'(1);
          if (cnt_q == WCW'(1)) begin
            cpl_valid <= 1'b1;
            cpl_irq   <= irq_q;
            cpl_err   <= 1'b0;
            st_q      <= W_IDLE;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  // R9
  empty_job_cpl_chk: assert property (@(posedge clk) disable iff (rst)
    (job_pop && (j_words == '0)) |=> cpl_valid && (cpl_irq == $past(j_irq)));
endmodule

// File: rtl/dma_fence_seq.sv
module dma_fence_seq #(
  parameter int AW        = 16,
  parameter int DW        = 64,
  parameter int LW        = 32,
  parameter int MAX_BYTES = 1 << 20,
  parameter int DDEPTH    = 8,
  parameter int JDEPTH    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt_clear,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [1:0]    desc_op,
  input  logic          desc_fence,
  input  logic          desc_irq,
  input  logic [AW-1:0] desc_src,
  input  logic [AW-1:0] desc_dst,
  input  logic [LW-1:0] desc_len,
  input  logic [DW-1:0] desc_pattern,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpl_valid,
  output logic          cpl_irq,
  output logic          cpl_err
);
  localparam int WCW = $clog2(MAX_BYTES / 8 + 1);
  localparam int JW  = AW + WCW + 2;
  localparam int DCW = $clog2(DDEPTH + 1);
  localparam int JCW = $clog2(JDEPTH + 1);

  logic           job_push, job_pop, job_done, job_full, job_empty;
  logic [JW-1:0]  job_in, job_out;
  logic [JCW-1:0] job_count;
  logic           dat_push, dat_pop, dat_empty;
  logic [DW-1:0]  dat_din, dat_dout;
  logic [DCW-1:0] dat_count;
  logic           rd_want, rd_go, wr_want, wr_go, pick_wr, slot_free, fwait;
  logic [AW-1:0]  rd_addr, wr_addr;
  logic [DW-1:0]  wr_data;
  logic           req_q, we_q, last_wr_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;

  assign job_full  = (job_count == JCW'(JDEPTH));
  assign job_empty = (job_count == '0);
  assign dat_empty = (dat_count == '0);

  dseq_fifo #(.W(JW), .DEPTH(JDEPTH)) i_job_q (
    .clk(clk), .rst(rst), .push(job_push), .din(job_in),
    .pop(job_pop), .dout(job_out), .count(job_count)
  );

  dseq_fifo #(.W(DW), .DEPTH(DDEPTH)) i_dat_q (
    .clk(clk), .rst(rst), .push(dat_push), .din(dat_din),
    .pop(dat_pop), .dout(dat_dout), .count(dat_count)
  );

  dseq_reader #(
    .AW(AW), .DW(DW), .LW(LW), .MAX_BYTES(MAX_BYTES), .DDEPTH(DDEPTH), .JDEPTH(JDEPTH)
  ) i_reader (
    .clk(clk), .rst(rst), .halt_clear(halt_clear),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_op(desc_op),
    .desc_fence(desc_fence), .desc_irq(desc_irq), .desc_src(desc_src),
    .desc_dst(desc_dst), .desc_len(desc_len), .desc_pattern(desc_pattern),
    .job_full(job_full), .job_push(job_push), .job_data(job_in), .job_done(job_done),
    .wr_in_port(req_q && we_q), .rd_want(rd_want), .rd_addr(rd_addr), .rd_go(rd_go),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dat_count(dat_count),
    .dat_push(dat_push), .dat_din(dat_din), .fwait(fwait)
  );

  dseq_writer #(.AW(AW), .DW(DW), .MAX_BYTES(MAX_BYTES)) i_writer (
    .clk(clk), .rst(rst), .job_empty(job_empty), .job_data(job_out), .job_pop(job_pop),
    .dat_empty(dat_empty), .dat_dout(dat_dout), .dat_pop(dat_pop),
    .wr_want(wr_want), .wr_addr(wr_addr), .wr_data(wr_data), .wr_go(wr_go),
    .job_done(job_done), .cpl_valid(cpl_valid), .cpl_irq(cpl_irq), .cpl_err(cpl_err)
  );

  // one request register; reader and writer alternate when both want it
  assign slot_free = !req_q || mem_gnt;
  assign pick_wr   = wr_want && (!rd_want || !last_wr_q);
  assign wr_go     = slot_free && pick_wr;
  assign rd_go     = slot_free && rd_want && !pick_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      last_wr_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else if (slot_free) begin
      req_q <= wr_go || rd_go;
      if (wr_go) begin
        we_q      <= 1'b1;
        addr_q    <= wr_addr;
        wdata_q   <= wr_data;
        last_wr_q <= 1'b1;
      end else if (rd_go) begin
        we_q      <= 1'b0;
        addr_q    <= rd_addr;
        last_wr_q <= 1'b0;
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R5
  fence_chk: assert property (@(posedge clk) disable iff (rst)
    (fwait && req_q && we_q) |=> !(mem_req && !mem_we));
endmodule

// File: tb/test_dma_fence_seq.sv
module test_dma_fence_seq;
  localparam int AW = 10;
  localparam int DW = 64;
  localparam int LW = 32;
  localparam int MAXB = 256;
  localparam int MWORDS = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, halt_clear = 1'b0;
  logic desc_valid = 1'b0, desc_ready, desc_fence = 1'b0, desc_irq = 1'b0;
  logic [1:0] desc_op = 2'd0;
  logic [AW-1:0] desc_src = '0, desc_dst = '0;
  logic [LW-1:0] desc_len = '0;
  logic [DW-1:0] desc_pattern = '0;
  logic mem_req, mem_we, mem_gnt = 1'b1, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic cpl_valid, cpl_irq, cpl_err;

  always #10 clk = ~clk;

  dma_fence_seq #(.AW(AW), .DW(DW), .LW(LW), .MAX_BYTES(MAXB), .DDEPTH(8), .JDEPTH(4))
  i_dma_fence_seq (
    .clk(clk), .rst(rst), .halt_clear(halt_clear), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_op(desc_op), .desc_fence(desc_fence),
    .desc_irq(desc_irq), .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
    .desc_pattern(desc_pattern), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cpl_valid(cpl_valid), .cpl_irq(cpl_irq), .cpl_err(cpl_err)
  );

  int checks = 0, errors = 0, cyc = 0, gcount = 0, hold_bad = 0, gnt_mode = 0;
  int watch_rd = -1, watch_wr = -1, rd_cyc = -1, wr_cyc = -1;
  int expq[$];
  logic [DW-1:0] mem [MWORDS];
  logic [DW-1:0] ref_mem [MWORDS];
  logic p_v = 1'b0;
  logic [AW-1:0] p_a = '0;
  logic hold_pend = 1'b0;
  logic [AW-1:0] hold_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory model: two-cycle read pipe, writes land at the grant edge
  initial forever begin
    @(posedge clk);
    if (hold_pend && (!mem_req || mem_addr != hold_addr)) hold_bad++;
    hold_pend = mem_req && !mem_gnt;
    hold_addr = mem_addr;
    if (!rst && mem_req && mem_gnt) begin
      gcount++;
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (int'(mem_addr) == watch_wr) wr_cyc = cyc;
      end else if (int'(mem_addr) == watch_rd && rd_cyc < 0) rd_cyc = cyc;
      p_v <= !mem_we;
      p_a <= mem_addr;
    end else p_v <= 1'b0;
    mem_rvalid <= p_v;
    mem_rdata  <= mem[p_a];
    cyc++;
  end

  initial forever begin
    @(negedge clk);
    mem_gnt = (gnt_mode == 0) ? 1'b1 : ((cyc % 3) != 2);
  end

  // completion monitor, every cycle
  initial forever begin
    @(negedge clk);
    if (!rst && cpl_valid) begin
      if (expq.size() == 0) check(1'b0, "R1", "unexpected completion", 1, 0);
      else begin
        int e;
        e = expq.pop_front();
        check((int'(cpl_irq) * 2 + int'(cpl_err)) == e, "R1 R10",
              "completion irq/err", int'(cpl_irq) * 2 + int'(cpl_err), e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic send(input logic [1:0] op, input bit fence, input bit irq,
                      input int src, input int dst, input int len, input logic [DW-1:0] pat);
    bit bad;
    bad = (op == 2'd3) || (op != 2'd0 && (len > MAXB || (len % 8) != 0));
    expq.push_back(int'(irq) * 2 + int'(bad));
    if (!bad && op == 2'd1) for (int i = 0; i < len / 8; i++) ref_mem[dst + i] = ref_mem[src + i];
    if (!bad && op == 2'd2) for (int i = 0; i < len / 8; i++) ref_mem[dst + i] = pat;
    @(negedge clk);
    desc_op = op; desc_fence = fence; desc_irq = irq;
    desc_src = AW'(src); desc_dst = AW'(dst); desc_len = LW'(len); desc_pattern = pat;
    desc_valid = 1'b1;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_halt();
    @(negedge clk); halt_clear = 1'b1;
    @(negedge clk); halt_clear = 1'b0;
  endtask

  task automatic expect_reject(input string req, input logic [1:0] op, input int len);
    int g0;
    g0 = gcount;
    send(op, 1'b0, 1'b1, 10, 960, len, 64'h1);
    drain();
    check(gcount == g0, req, "rejected descriptor touched memory", gcount, g0);
    check(desc_ready == 1'b0, "R11", "ready while halted", desc_ready, 0);
    clear_halt();
    check(desc_ready == 1'b1, "R11", "ready after clear", desc_ready, 1);
  endtask

  initial begin
    int g0, bad_words, seen;
    for (int i = 0; i < MWORDS; i++) begin
      mem[i] = {32'hC0DE0000 + 32'(i), 32'(i * 7)};
      ref_mem[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(desc_ready == 1'b1, "R13", "reset ready", desc_ready, 1);
    check(mem_req == 1'b0, "R13", "reset mem_req", mem_req, 0);
    check(cpl_valid == 1'b0, "R13", "reset cpl_valid", cpl_valid, 0);

    // R2 R3 R4 R1: mixed stream
    send(2'd1, 1'b0, 1'b1, 0, 100, 64, '0);
    send(2'd2, 1'b0, 1'b0, 0, 200, 40, 64'hDEAD_BEEF_0123_4567);
    send(2'd0, 1'b0, 1'b1, 0, 0, 0, '0);
    send(2'd0, 1'b0, 1'b0, 0, 0, 0, '0);
    drain();
    check(mem[107] == ref_mem[107], "R2", "copy last word", mem[107], ref_mem[107]);
    check(mem[204] == 64'hDEAD_BEEF_0123_4567, "R3", "fill last word", mem[204], 64'hDEAD_BEEF_0123_4567);

    // R4 empty op (odd length field), R9 zero-length copy
    g0 = gcount;
    send(2'd0, 1'b1, 1'b1, 5, 6, 12, '0);
    drain();
    check(gcount == g0, "R4", "empty op memory grants", gcount, g0);
    g0 = gcount;
    send(2'd1, 1'b0, 1'b0, 5, 6, 0, '0);
    send(2'd2, 1'b1, 1'b1, 5, 6, 0, 64'h5);
    drain();
    check(gcount == g0, "R9", "zero length memory grants", gcount, g0);

    // R6 read-ahead without fence
    watch_rd = 500; watch_wr = 407; rd_cyc = -1; wr_cyc = -1;
    send(2'd1, 1'b0, 1'b0, 300, 400, 64, '0);
    send(2'd1, 1'b0, 1'b1, 500, 600, 32, '0);
    drain();
    check(rd_cyc >= 0 && rd_cyc < wr_cyc, "R6", "next read before last write", rd_cyc, wr_cyc);

    // R5 fenced dependent copy
    watch_rd = 700; watch_wr = 703; rd_cyc = -1; wr_cyc = -1;
    send(2'd1, 1'b0, 1'b0, 300, 700, 32, '0);
    send(2'd1, 1'b1, 1'b1, 700, 800, 32, '0);
    drain();
    check(rd_cyc > wr_cyc, "R5", "fenced read after last write", rd_cyc, wr_cyc);
    check(mem[803] == ref_mem[303], "R5", "fenced copy data", mem[803], ref_mem[303]);

    // R1 R13 with throttled grants
    gnt_mode = 1;
    send(2'd2, 1'b0, 1'b1, 0, 220, 24, 64'hA5A5_A5A5_5A5A_5A5A);
    send(2'd1, 1'b0, 1'b0, 40, 240, 48, '0);
    send(2'd0, 1'b0, 1'b1, 0, 0, 0, '0);
    send(2'd1, 1'b1, 1'b1, 240, 260, 48, '0);
    drain();
    gnt_mode = 0;
    check(hold_bad == 0, "R13", "request changed before grant", hold_bad, 0);

    // R7 exact maximum accepted
    send(2'd1, 1'b0, 1'b1, 0, 900, MAXB, '0);
    drain();
    check(mem[931] == ref_mem[931], "R7", "max length copy data", mem[931], ref_mem[931]);

    // R7 oversize, R11 halt behaviour
    g0 = gcount;
    send(2'd1, 1'b0, 1'b1, 0, 950, MAXB + 8, '0);
    drain();
    check(gcount == g0, "R7", "oversize touched memory", gcount, g0);
    seen = 0;
    @(negedge clk);
    desc_op = 2'd0; desc_irq = 1'b1; desc_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (desc_ready) seen++;
    end
    desc_valid = 1'b0;
    check(seen == 0, "R11", "accepted while halted", seen, 0);
    clear_halt();
    send(2'd0, 1'b0, 1'b1, 0, 0, 0, '0);
    drain();

    expect_reject("R8", 2'd1, 12);
    expect_reject("R8", 2'd2, 4);
    expect_reject("R12", 2'd3, 8);

    bad_words = 0;
    for (int i = 0; i < MWORDS; i++) if (mem[i] !== ref_mem[i]) bad_words++;
    check(bad_words == 0, "R2 R3", "memory image mismatches", bad_words, 0);
    check(expq.size() == 0, "R1", "missing completions", expq.size(), 0);
    finish_run();
  end
endmodule